// File: doc/BRIEF.md
# Dual Split Decade Counter

The block holds two identical, independent 4-bit counting halves. Each half has a divide-by-two stage, which drives Q0, and a divide-by-five stage, which drives Q3:Q1. Each stage has its own count input and advances when that input falls. A per-half clear, active high, forces all four outputs of that half to zero.

All logic runs on one free-running system clock. The external count inputs are synchronised through a short flip-flop chain and then edge-detected. A per-half link select stands in for board wiring between the two stages. With one setting the stages count apart. With another, Q0 feeds the divide-by-five stage and the half counts 0 to 9 in 8421 BCD. With the third, Q3 feeds the divide-by-two stage: the half runs a biquinary sequence, and Q0 carries a square wave at one tenth of the input rate with 50% duty. Each internal feed is edge-detected on the clock, so every stage in the chain adds one clock of latency.

Top module: `dual_split_decade_counter`

## Requirements
- R1: While rst_ni is low, every bit of q_o reads 0, and the effect is immediate, without waiting for a clock edge.
- R2: Half h occupies q_o[4h+3:4h], with Q0 in bit 4h. With link select 0 (or 3), Q0 toggles once for each falling edge of cnt2_i[h]. The new value appears on the third rising clock edge after the input falls.
- R3: Q3:Q1 of a half counts 0,1,2,3,4 in binary on falling edges of its divide-by-five count source, then wraps from 4 to 0. Rising edges have no effect. Q3 falls only on the 4-to-0 wrap.
- R4: With link select 1, falls of Q0 advance the divide-by-five stage and the half counts 0..9 in 8421 BCD, then wraps to 0. cnt5_i[h] is ignored.
- R5: With link select 2, falls of Q3 toggle Q0 and cnt5_i[h] drives the divide-by-five stage. Ten cnt5_i falls from zero give q values 2,4,6,8,1,3,5,7,9,0, so Q0 is high for five counts and low for five. cnt2_i[h] is ignored.
- R6: While clr_i[h] is high, that half's outputs are 0 from the next clock edge on, and count edges have no effect.
- R7: A clear sampled on the same clock edge at which a count edge would be applied wins, and the count is lost.
- R8: Stimulus, clear and link select of one half do not change the outputs of the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt2_i | input | 2 | Divide-by-two count input, one bit per half |
| cnt5_i | input | 2 | Divide-by-five count input, one bit per half |
| clr_i | input | 2 | Synchronous clear, active high, one bit per half |
| link_i | input | 4 | Stage link select, two bits per half: 0 none, 1 BCD, 2 biquinary, 3 none |
| q_o | output | 8 | Counter outputs, four bits per half, Q0 in the low bit |

## Verification
The bench walks a half through the 9-to-0 BCD rollover, where a cascade that also reacted to Q3 would produce a spurious step. It also walks the biquinary wrap, where a missing Q3 feed would leave Q0 stuck and break the 2,4,6,8,1 pattern. It pulses the input that each link mode should ignore: a design that still listened would show an extra count. A clear is placed on exactly the edge at which a pending count lands, so a design with the wrong priority would leave Q0 at 1. Finally, it checks the three-edge latency and that activity in one half leaves the other half untouched.

// File: rtl/dsdc_pkg.sv
package dsdc_pkg;
  typedef enum logic [1:0] {
    LINK_NONE = 2'd0,
    LINK_BCD  = 2'd1,
    LINK_BIQ  = 2'd2,
    LINK_RSV  = 2'd3
  } link_e;

  localparam int unsigned DIV5_W = 3;
  localparam int unsigned HALF_W = DIV5_W + 1;
endpackage

// File: rtl/dsdc_fall_sync.sv
module dsdc_fall_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic fall_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= din_i;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[LAST];
  end

  assign fall_o = last_q & ~sync_q[LAST];

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dsdc_div5.sv
module dsdc_div5 (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          adv_i,
  output logic [dsdc_pkg::DIV5_W-1:0]   cnt_o
);
  import dsdc_pkg::*;

  logic [DIV5_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    case (cnt_q)
      3'd0:    cnt_nxt = 3'd1;
      3'd1:    cnt_nxt = 3'd2;
      3'd2:    cnt_nxt = 3'd3;
      3'd3:    cnt_nxt = 3'd4;
      default: cnt_nxt = 3'd0; // 4 wraps, 5..7 recover
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R3
  wrap_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnt_q[2]) |-> ($past(cnt_q) == 3'd4 || $past(clr_i)));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/dsdc_half.sv
module dsdc_half #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cnt2_i,
  input  logic                          cnt5_i,
  input  logic                          clr_i,
  input  dsdc_pkg::link_e               link_i,
  output logic [dsdc_pkg::HALF_W-1:0]   q_o
);
  import dsdc_pkg::*;

  logic              fall2_ext, fall5_ext;
  logic              q0_q, q0_last_q, q3_last_q;
  logic              fall_q0, fall_q3;
  logic              adv2, adv5;
  logic [DIV5_W-1:0] d5_cnt;

  dsdc_fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(cnt2_i), .fall_o(fall2_ext)
  );

  dsdc_fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync5 (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(cnt5_i), .fall_o(fall5_ext)
  );

  // cascade taps: same falling-edge rule as the external inputs
  assign fall_q0 = q0_last_q & ~q0_q;
  assign fall_q3 = q3_last_q & ~d5_cnt[2];

  assign adv2 = (link_i == LINK_BIQ) ? fall_q3 : fall2_ext;
  assign adv5 = (link_i == LINK_BCD) ? fall_q0 : fall5_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q0_q      <= 1'b0;
      q0_last_q <= 1'b0;
      q3_last_q <= 1'b0;
    end else if (clr_i) begin
      q0_q      <= 1'b0;
      q0_last_q <= 1'b0;
      q3_last_q <= 1'b0;
    end else begin
      if (adv2) q0_q <= ~q0_q;
      q0_last_q <= q0_q;
      q3_last_q <= d5_cnt[2];
    end
  end

  dsdc_div5 u_div5 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .adv_i(adv5), .cnt_o(d5_cnt)
  );

  assign q_o = {d5_cnt, q0_q};

  // R6
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));

  // R2
  q0_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q0_q) |-> $past(adv2 || clr_i));
endmodule

// File: rtl/dual_split_decade_counter.sv
module dual_split_decade_counter #(
  parameter int unsigned NUM_HALVES  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_HALVES-1:0]   cnt2_i,
  input  logic [NUM_HALVES-1:0]   cnt5_i,
  input  logic [NUM_HALVES-1:0]   clr_i,
  input  logic [2*NUM_HALVES-1:0] link_i,
  output logic [4*NUM_HALVES-1:0] q_o
);
  import dsdc_pkg::*;

  localparam int unsigned LW = 2;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    dsdc_half #(.SYNC_STAGES(SYNC_STAGES)) u_half (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt2_i(cnt2_i[g]),
      .cnt5_i(cnt5_i[g]),
      .clr_i (clr_i[g]),
      .link_i(link_e'(link_i[LW*g +: LW])),
      .q_o   (q_o[HALF_W*g +: HALF_W])
    );
  end
endmodule

// File: tb/dual_split_decade_counter_tb.sv
module dual_split_decade_counter_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cnt2 = 2'b11, cnt5 = 2'b11, clr = 2'b00;
  logic [3:0] link = 4'h0;
  logic [7:0] q;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_split_decade_counter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt2_i(cnt2), .cnt5_i(cnt5),
    .clr_i(clr), .link_i(link), .q_o(q)
  );

  // {link[7:6], src[5:4] 0=cnt2 1=cnt5, expected half-0 value[3:0]}
  localparam int NV = 29;
  localparam logic [7:0] VEC [NV] = '{
    {2'd0,2'd0,4'd1}, {2'd0,2'd0,4'd0}, {2'd0,2'd1,4'd2}, {2'd0,2'd1,4'd4},
    {2'd0,2'd1,4'd6}, {2'd0,2'd1,4'd8}, {2'd0,2'd1,4'd0},
    {2'd1,2'd1,4'd0}, {2'd1,2'd0,4'd1}, {2'd1,2'd0,4'd2}, {2'd1,2'd0,4'd3},
    {2'd1,2'd0,4'd4}, {2'd1,2'd0,4'd5}, {2'd1,2'd0,4'd6}, {2'd1,2'd0,4'd7},
    {2'd1,2'd0,4'd8}, {2'd1,2'd0,4'd9}, {2'd1,2'd0,4'd0},
    {2'd2,2'd0,4'd0}, {2'd2,2'd1,4'd2}, {2'd2,2'd1,4'd4}, {2'd2,2'd1,4'd6},
    {2'd2,2'd1,4'd8}, {2'd2,2'd1,4'd1}, {2'd2,2'd1,4'd3}, {2'd2,2'd1,4'd5},
    {2'd2,2'd1,4'd7}, {2'd2,2'd1,4'd9}, {2'd2,2'd1,4'd0}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int h, input bit on5);
    @(negedge clk);
    if (on5) cnt5[h] = 1'b0; else cnt2[h] = 1'b0;
    repeat (6) @(negedge clk);
    if (on5) cnt5[h] = 1'b1; else cnt2[h] = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 async reset", q[3:0], 4'd0);
    chk("R1 async reset h1", q[7:4], 4'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R2 R3 independent, R4 BCD, R5 biquinary, R8 other half idle
    for (int i = 0; i < NV; i++) begin
      link[1:0] = VEC[i][7:6];
      pulse(0, VEC[i][4]);
      chk(VEC[i][7:6] == 2'd0 ? "R2/R3 indep" :
          VEC[i][7:6] == 2'd1 ? "R4 bcd" : "R5 biquinary", q[3:0], VEC[i][3:0]);
      chk("R8 half1 idle", q[7:4], 4'd0);
    end

    // R2 latency: change on third rising edge
    link[1:0] = 2'd0;
    @(negedge clk); cnt2[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 latency early", q[3:0], 4'd0);
    @(negedge clk);
    chk("R2 latency edge3", q[3:0], 4'd1);
    repeat (4) @(negedge clk); cnt2[0] = 1'b1;
    repeat (4) @(negedge clk);

    // R2 link code 3 behaves as independent
    link[1:0] = 2'd3;
    pulse(0, 1'b1);
    chk("R2 link3 indep", q[3:0], 4'd3);

    // R6 clear holds zero, edges ignored
    @(negedge clk); clr[0] = 1'b1;
    @(negedge clk);
    chk("R6 clear", q[3:0], 4'd0);
    pulse(0, 1'b0);
    pulse(0, 1'b1);
    chk("R6 clear hold", q[3:0], 4'd0);
    clr[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 after release", q[3:0], 4'd0);

    // R7 clear on the exact edge that applies a count
    link[1:0] = 2'd0;
    @(negedge clk); cnt2[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); clr[0] = 1'b1;
    @(negedge clk); clr[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 clear priority", q[3:0], 4'd0);
    cnt2[0] = 1'b1;
    repeat (6) @(negedge clk);

    // R8 half 1 alone
    link[3:2] = 2'd0;
    pulse(0, 1'b0);
    pulse(1, 1'b1);
    chk("R8 half1 count", q[7:4], 4'd2);
    chk("R8 half0 kept", q[3:0], 4'd1);
    @(negedge clk); clr[1] = 1'b1;
    @(negedge clk); clr[1] = 1'b0;
    @(negedge clk);
    chk("R8 half1 cleared", q[7:4], 4'd0);
    chk("R8 half0 unaffected", q[3:0], 4'd1);

    // R1 mid-run asynchronous reset
    pulse(1, 1'b0);
    @(negedge clk); #1 rst_ni = 1'b0; #0.5;
    chk("R1 reset mid h0", q[3:0], 4'd0);
    chk("R1 reset mid h1", q[7:4], 4'd0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule